// File: doc/BRIEF.md
# Per-port per-class transmit queue manager

This block holds the unicast transmit queues of a small switch as linked lists of frame handles. There is one list for each class of each port. Ports 0 to 7 have two classes each. Ports 8 and 9 (the gigabit uplink and the CPU port) have four classes each. That makes 24 queues in total. The lists are threaded through a single next-pointer table of 256 entries indexed by handle. Each queue keeps its own head, tail and occupancy count.

A lookup result arrives as a handle, a destination port and a 3-bit priority. The block maps the priority onto one of the port's classes. It then admits or drops the frame, based on global buffer usage against a threshold and on the occupancy of the target queue. An admitted handle is appended at the tail of its list. A dropped handle is handed back on the release output in the same cycle.

When a port has room for another frame, it raises a dequeue request. The block answers in the same cycle with the head handle of the highest non-empty class of that port. That handle is unlinked at the next clock edge.

Top module: `txq_list_mgr`

## Requirements
- R1: After reset every queue is empty, so a dequeue request on any port returns `deq_valid` = 0.
- R2: For ports 0 to 7 the class is priority bit 2 (priorities 4 to 7 go to class 1, priorities 0 to 3 to class 0), and handles within one queue leave in arrival order.
- R3: For ports 8 and 9 the class is priority bits 2:1 (class = priority / 2, range 0 to 3).
- R4: A dequeue request returns, in the same cycle, the head handle of the highest-numbered non-empty class of the requested port, with that class number on `deq_cls`; the handle is removed at the next clock edge.
- R5: A frame offered while `buf_used` >= `buf_limit` is dropped: `rel_valid` = 1 and `rel_handle` equals `enq_handle` in the same cycle, and the handle is not queued. `buf_used` = `buf_limit` - 1 does not by itself cause a drop.
- R6: A frame whose target queue already holds `q_limit` or more handles is dropped in the same way as in R5.
- R7: A frame addressed to a port number of 10 or above is always dropped; a dequeue request for such a port returns `deq_valid` = 0.
- R8: An admitted frame gives `rel_valid` = 0 and is appended at the tail of its queue; `rel_valid` is never high without `enq_valid`.
- R9: A dequeue request on a port whose queues are all empty returns `deq_valid` = 0 and changes no queue; `deq_valid` is never high without `deq_req`.
- R10: An append and a dequeue on the same queue in one cycle both take effect, including when the queue holds exactly one handle; the queue count changes by at most one per cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| enq_valid | input | 1 | Lookup response present this cycle |
| enq_port | input | 4 | Destination port of the response |
| enq_prio | input | 3 | Priority of the frame (0 to 7) |
| enq_handle | input | 8 | Frame handle |
| buf_used | input | 10 | Current global frame buffer usage |
| buf_limit | input | 10 | Global usage threshold for admission |
| q_limit | input | 9 | Per-queue occupancy limit |
| rel_valid | output | 1 | Offered frame dropped; handle released |
| rel_handle | output | 8 | Released handle |
| deq_req | input | 1 | Port requests its next frame |
| deq_port | input | 4 | Requesting port |
| deq_valid | output | 1 | A handle is returned |
| deq_handle | output | 8 | Returned head-of-line handle |
| deq_cls | output | 2 | Class the handle came from |

## Verification
The bench goes after an append and a dequeue on the same one-entry queue in one cycle. A design that follows the stale next pointer there would return a handle that was never queued, or would lose the new frame. It also drives buffer usage exactly at the threshold and one below it, and fills a queue exactly to its limit. An off-by-one comparison would then drop a frame that should have been kept, or keep one that should have been dropped. Mixed-class traffic on the two-class and four-class ports, together with out-of-range port numbers, exposes a wrong priority-to-class shift, an inverted strict-priority order, or a write past the last queue.

// File: rtl/txq_pkg.sv
// Shared constants and mapping helpers for the transmit queue manager.
// Assumes two port groups: small ports with few classes, then big ports
// with more classes, with queues numbered port by port.
package txq_pkg;
    localparam int SMALL_PORTS = 8;
    localparam int SMALL_CLS   = 2;
    localparam int BIG_PORTS   = 2;
    localparam int BIG_CLS     = 4;
    localparam int PRIO_W      = 3;
    localparam int NUM_PORTS   = SMALL_PORTS + BIG_PORTS;
    localparam int NUM_Q       = SMALL_PORTS * SMALL_CLS + BIG_PORTS * BIG_CLS;
    localparam int PORT_W      = $clog2(NUM_PORTS);
    localparam int QIDX_W      = $clog2(NUM_Q);
    localparam int MAX_CLS     = (BIG_CLS > SMALL_CLS) ? BIG_CLS : SMALL_CLS;
    localparam int CLS_W       = $clog2(MAX_CLS);
    localparam int SMALL_SHIFT = PRIO_W - $clog2(SMALL_CLS);
    localparam int BIG_SHIFT   = PRIO_W - $clog2(BIG_CLS);

    // True when the port number names a real port.
    function automatic logic port_ok(input logic [PORT_W-1:0] p);
        return int'(p) < NUM_PORTS;
    endfunction

    // Number of classes owned by a port.
    function automatic int n_cls(input logic [PORT_W-1:0] p);
        return (int'(p) < SMALL_PORTS) ? SMALL_CLS : BIG_CLS;
    endfunction

    // Index of class 0 of a port.
    function automatic logic [QIDX_W-1:0] q_base(input logic [PORT_W-1:0] p);
        if (int'(p) < SMALL_PORTS)
            return QIDX_W'(int'(p) * SMALL_CLS);
        return QIDX_W'(SMALL_PORTS * SMALL_CLS + (int'(p) - SMALL_PORTS) * BIG_CLS);
    endfunction

    // Class chosen by the top bits of the priority.
    function automatic logic [CLS_W-1:0] prio_to_cls(input logic [PORT_W-1:0] p,
                                                     input logic [PRIO_W-1:0] prio);
        if (int'(p) < SMALL_PORTS)
            return CLS_W'(prio >> SMALL_SHIFT);
        return CLS_W'(prio >> BIG_SHIFT);
    endfunction
endpackage

// File: rtl/txq_admit.sv
// Admission stage: maps a lookup response to its queue and decides to
// link or drop it. Purely combinational; uses queue counts from before
// the current cycle's updates.
module txq_admit
    import txq_pkg::*;
#(
    parameter int HANDLE_W = 8,
    parameter int BUF_W    = 10,
    parameter int CNT_W    = HANDLE_W + 1
) (
    input  logic                          enq_valid,
    input  logic [PORT_W-1:0]             enq_port,
    input  logic [PRIO_W-1:0]             enq_prio,
    input  logic [HANDLE_W-1:0]           enq_handle,
    input  logic [BUF_W-1:0]              buf_used,
    input  logic [BUF_W-1:0]              buf_limit,
    input  logic [CNT_W-1:0]              q_limit,
    input  logic [NUM_Q-1:0][CNT_W-1:0]   q_cnt,
    output logic                          push,
    output logic [QIDX_W-1:0]             push_q,
    output logic                          rel_valid,
    output logic [HANDLE_W-1:0]           rel_handle
);
    logic ok_port;
    logic glob_full;
    logic q_full;

    // Target queue and the admit/drop decision.
    always_comb begin
        ok_port   = port_ok(enq_port);
        push_q    = ok_port ? (q_base(enq_port) + QIDX_W'(prio_to_cls(enq_port, enq_prio)))
                            : '0;
        glob_full = (buf_used >= buf_limit);
        q_full    = ok_port ? (q_cnt[push_q] >= q_limit) : 1'b1;
        push      = enq_valid && ok_port && !glob_full && !q_full;
        rel_valid = enq_valid && !push;
        rel_handle = enq_handle;
    end
endmodule

// File: rtl/txq_sched.sv
// Strict-priority selector: for the requesting port, returns the head of
// the highest-numbered non-empty class. Combinational; the store unlinks
// the selected handle at the next edge.
module txq_sched
    import txq_pkg::*;
#(
    parameter int HANDLE_W = 8,
    parameter int CNT_W    = HANDLE_W + 1
) (
    input  logic                          deq_req,
    input  logic [PORT_W-1:0]             deq_port,
    input  logic [NUM_Q-1:0][CNT_W-1:0]   q_cnt,
    input  logic [NUM_Q-1:0][HANDLE_W-1:0] q_head,
    output logic                          pop,
    output logic [QIDX_W-1:0]             pop_q,
    output logic [HANDLE_W-1:0]           deq_handle,
    output logic [CLS_W-1:0]              deq_cls
);
    logic [QIDX_W-1:0] base;
    int                ncls;

    // Scan classes upward so the highest non-empty one wins.
    always_comb begin
        base    = q_base(deq_port);
        ncls    = n_cls(deq_port);
        pop     = 1'b0;
        pop_q   = '0;
        deq_cls = '0;
        if (deq_req && port_ok(deq_port)) begin
            for (int c = 0; c < MAX_CLS; c++) begin
                if (c < ncls && q_cnt[base + QIDX_W'(c)] != '0) begin
                    pop     = 1'b1;
                    pop_q   = base + QIDX_W'(c);
                    deq_cls = CLS_W'(c);
                end
            end
        end
        deq_handle = q_head[pop_q];
    end
endmodule

// File: rtl/txq_store.sv
// Linked-list storage: per-queue head, tail and count registers plus a
// shared next-pointer table indexed by handle. Assumes a handle sits in at
// most one queue at a time, and that pop is only raised for a non-empty
// queue. The table itself needs no reset.
module txq_store
    import txq_pkg::*;
#(
    parameter int HANDLE_W = 8,
    parameter int CNT_W    = HANDLE_W + 1
) (
    input  logic                           clk,
    input  logic                           rst_n,
    input  logic                           push,
    input  logic [QIDX_W-1:0]              push_q,
    input  logic [HANDLE_W-1:0]            push_handle,
    input  logic                           pop,
    input  logic [QIDX_W-1:0]              pop_q,
    output logic [NUM_Q-1:0][HANDLE_W-1:0] q_head,
    output logic [NUM_Q-1:0][CNT_W-1:0]    q_cnt
);
    localparam int DEPTH = 1 << HANDLE_W;

    logic [HANDLE_W-1:0] nxt [DEPTH];
    logic [NUM_Q-1:0][HANDLE_W-1:0] q_tail;

    // Link the new handle behind the current tail of a non-empty queue.
    always_ff @(posedge clk) begin
        if (push && q_cnt[push_q] != '0)
            nxt[q_tail[push_q]] <= push_handle;
    end

    for (genvar q = 0; q < NUM_Q; q++) begin : g_q
        logic                do_push;
        logic                do_pop;
        logic [HANDLE_W-1:0] head_r;
        logic [HANDLE_W-1:0] tail_r;
        logic [CNT_W-1:0]    cnt_r;

        assign do_push  = push && (push_q == QIDX_W'(q));
        assign do_pop   = pop && (pop_q == QIDX_W'(q));
        assign q_head[q] = head_r;
        assign q_tail[q] = tail_r;
        assign q_cnt[q]  = cnt_r;

        // Update head, tail and count for this queue.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                head_r <= '0;
                tail_r <= '0;
                cnt_r  <= '0;
            end else begin
                if (do_push)
                    tail_r <= push_handle;
                if (do_pop) begin
                    if (cnt_r == CNT_W'(1))
                        head_r <= push_handle;
                    else
                        head_r <= nxt[head_r];
                end else if (do_push && cnt_r == '0) begin
                    head_r <= push_handle;
                end
                cnt_r <= cnt_r + CNT_W'(do_push) - CNT_W'(do_pop);
            end
        end
    end
endmodule

// File: rtl/txq_list_mgr.sv
// Top of the per-port per-class transmit queue manager. Wires admission,
// strict-priority selection and linked-list storage together. Release and
// dequeue outputs are combinational from the inputs and the queue state.
module txq_list_mgr
    import txq_pkg::*;
#(
    parameter int HANDLE_W = 8,
    parameter int BUF_W    = 10
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  enq_valid,
    input  logic [PORT_W-1:0]     enq_port,
    input  logic [PRIO_W-1:0]     enq_prio,
    input  logic [HANDLE_W-1:0]   enq_handle,
    input  logic [BUF_W-1:0]      buf_used,
    input  logic [BUF_W-1:0]      buf_limit,
    input  logic [HANDLE_W:0]     q_limit,
    output logic                  rel_valid,
    output logic [HANDLE_W-1:0]   rel_handle,
    input  logic                  deq_req,
    input  logic [PORT_W-1:0]     deq_port,
    output logic                  deq_valid,
    output logic [HANDLE_W-1:0]   deq_handle,
    output logic [CLS_W-1:0]      deq_cls
);
    localparam int CNT_W = HANDLE_W + 1;

    logic                           push;
    logic [QIDX_W-1:0]              push_q;
    logic [QIDX_W-1:0]              pop_q;
    logic [NUM_Q-1:0][HANDLE_W-1:0] q_head;
    logic [NUM_Q-1:0][CNT_W-1:0]    q_cnt;

    txq_admit #(.HANDLE_W(HANDLE_W), .BUF_W(BUF_W), .CNT_W(CNT_W)) admit_i (
        .enq_valid (enq_valid),
        .enq_port  (enq_port),
        .enq_prio  (enq_prio),
        .enq_handle(enq_handle),
        .buf_used  (buf_used),
        .buf_limit (buf_limit),
        .q_limit   (q_limit),
        .q_cnt     (q_cnt),
        .push      (push),
        .push_q    (push_q),
        .rel_valid (rel_valid),
        .rel_handle(rel_handle)
    );

    txq_sched #(.HANDLE_W(HANDLE_W), .CNT_W(CNT_W)) sched_i (
        .deq_req   (deq_req),
        .deq_port  (deq_port),
        .q_cnt     (q_cnt),
        .q_head    (q_head),
        .pop       (deq_valid),
        .pop_q     (pop_q),
        .deq_handle(deq_handle),
        .deq_cls   (deq_cls)
    );

    txq_store #(.HANDLE_W(HANDLE_W), .CNT_W(CNT_W)) store_i (
        .clk        (clk),
        .rst_n      (rst_n),
        .push       (push),
        .push_q     (push_q),
        .push_handle(enq_handle),
        .pop        (deq_valid),
        .pop_q      (pop_q),
        .q_head     (q_head),
        .q_cnt      (q_cnt)
    );
endmodule

// File: rtl/txq_list_mgr_chk.sv
// Assertion checker for the transmit queue manager, attached by bind.
// Observes the top ports and the per-queue counts.
module txq_list_mgr_chk
    import txq_pkg::*;
#(
    parameter int HANDLE_W = 8,
    parameter int BUF_W    = 10
) (
    input logic                              clk,
    input logic                              rst_n,
    input logic                              enq_valid,
    input logic [PORT_W-1:0]                 enq_port,
    input logic [HANDLE_W-1:0]               enq_handle,
    input logic [BUF_W-1:0]                  buf_used,
    input logic [BUF_W-1:0]                  buf_limit,
    input logic                              rel_valid,
    input logic [HANDLE_W-1:0]               rel_handle,
    input logic                              deq_req,
    input logic                              deq_valid,
    input logic [NUM_Q-1:0][HANDLE_W:0]      q_cnt
);
    p_glob_drop_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (enq_valid && buf_used >= buf_limit) |-> (rel_valid && rel_handle == enq_handle));

    p_bad_port_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (enq_valid && int'(enq_port) >= NUM_PORTS) |-> rel_valid);

    p_rel_needs_enq_r8: assert property (@(posedge clk) disable iff (!rst_n)
        rel_valid |-> enq_valid);

    p_deq_needs_req_r9: assert property (@(posedge clk) disable iff (!rst_n)
        deq_valid |-> deq_req);

    for (genvar q = 0; q < NUM_Q; q++) begin : g_cnt
        p_cnt_step_r10: assert property (@(posedge clk) disable iff (!rst_n)
            (q_cnt[q] == $past(q_cnt[q])) ||
            (q_cnt[q] == $past(q_cnt[q]) + (HANDLE_W+1)'(1)) ||
            (q_cnt[q] == $past(q_cnt[q]) - (HANDLE_W+1)'(1)));
    end
endmodule

bind txq_list_mgr txq_list_mgr_chk #(.HANDLE_W(HANDLE_W), .BUF_W(BUF_W)) chk_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .enq_valid (enq_valid),
    .enq_port  (enq_port),
    .enq_handle(enq_handle),
    .buf_used  (buf_used),
    .buf_limit (buf_limit),
    .rel_valid (rel_valid),
    .rel_handle(rel_handle),
    .deq_req   (deq_req),
    .deq_valid (deq_valid),
    .q_cnt     (q_cnt)
);

// File: tb/txq_list_mgr_tb.sv
// Bench for txq_list_mgr: directed corner cases followed by seeded random
// traffic, checked against a queue model kept in the bench.
module txq_list_mgr_tb_top;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       enq_valid = 1'b0;
    logic [3:0] enq_port = '0;
    logic [2:0] enq_prio = '0;
    logic [7:0] enq_handle = '0;
    logic [9:0] buf_used = '0;
    logic [9:0] buf_limit = 10'd200;
    logic [8:0] q_limit = 9'd6;
    logic       rel_valid;
    logic [7:0] rel_handle;
    logic       deq_req = 1'b0;
    logic [3:0] deq_port = '0;
    logic       deq_valid;
    logic [7:0] deq_handle;
    logic [1:0] deq_cls;

    int tests = 0;
    int fails = 0;
    logic [7:0] mq [24][$];
    bit inuse [256];

    txq_list_mgr dut_i (
        .clk(clk), .rst_n(rst_n), .enq_valid(enq_valid), .enq_port(enq_port),
        .enq_prio(enq_prio), .enq_handle(enq_handle), .buf_used(buf_used),
        .buf_limit(buf_limit), .q_limit(q_limit), .rel_valid(rel_valid),
        .rel_handle(rel_handle), .deq_req(deq_req), .deq_port(deq_port),
        .deq_valid(deq_valid), .deq_handle(deq_handle), .deq_cls(deq_cls)
    );

    always #5ns clk = ~clk;

    function automatic int ncls_of(int p);
        return (p < 8) ? 2 : 4;
    endfunction

    function automatic int qidx(int p, int c);
        return (p < 8) ? p * 2 + c : 16 + (p - 8) * 4 + c;
    endfunction

    function automatic int cls_of(int p, int prio);
        return (p < 8) ? prio / 4 : prio / 2;
    endfunction

    task automatic check(bit ok, string tag, string what, int act, int exp);
        tests++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s: actual %0d expected %0d", tag, what, act, exp);
        end
    endtask

    // One cycle: drive at negedge, check before posedge, update the model after.
    task automatic step(bit ev, int ep, int epr, int eh, bit dr, int dp, string tag);
        bit    exp_rel;
        bit    exp_dv;
        int    exp_h;
        int    exp_c;
        int    tq;
        int    dq;
        string etag;
        string dtag;
        enq_valid  = ev;
        enq_port   = 4'(ep);
        enq_prio   = 3'(epr);
        enq_handle = 8'(eh);
        deq_req    = dr;
        deq_port   = 4'(dp);
        exp_rel = 1'b0;
        tq = -1;
        etag = "R8";
        if (ev) begin
            if (ep >= 10) begin
                exp_rel = 1'b1; etag = "R7";
            end else begin
                tq = qidx(ep, cls_of(ep, epr));
                if (buf_used >= buf_limit) begin
                    exp_rel = 1'b1; etag = "R5";
                end else if (mq[tq].size() >= int'(q_limit)) begin
                    exp_rel = 1'b1; etag = "R6";
                end
            end
        end
        exp_dv = 1'b0; exp_h = 0; exp_c = 0; dq = -1;
        dtag = (dr && dp >= 10) ? "R7" : "R9";
        if (dr && dp < 10) begin
            for (int c = ncls_of(dp) - 1; c >= 0; c--) begin
                if (!exp_dv && mq[qidx(dp, c)].size() != 0) begin
                    exp_dv = 1'b1; exp_c = c; dq = qidx(dp, c);
                    exp_h = int'(mq[dq][0]); dtag = "R4";
                end
            end
        end
        if (tag != "") begin
            etag = tag; dtag = tag;
        end
        #4ns;
        if (ev) begin
            check(rel_valid == exp_rel, etag, "rel_valid", int'(rel_valid), int'(exp_rel));
            if (exp_rel)
                check(rel_handle == 8'(eh), etag, "rel_handle", int'(rel_handle), eh);
        end else begin
            check(rel_valid == 1'b0, "R8", "rel_valid idle", int'(rel_valid), 0);
        end
        if (dr) begin
            check(deq_valid == exp_dv, dtag, "deq_valid", int'(deq_valid), int'(exp_dv));
            if (exp_dv) begin
                check(int'(deq_handle) == exp_h, dtag, "deq_handle", int'(deq_handle), exp_h);
                check(int'(deq_cls) == exp_c, dtag, "deq_cls", int'(deq_cls), exp_c);
            end
        end else begin
            check(deq_valid == 1'b0, "R9", "deq_valid idle", int'(deq_valid), 0);
        end
        @(posedge clk);
        if (dq >= 0) begin
            inuse[mq[dq][0]] = 1'b0;
            void'(mq[dq].pop_front());
        end
        if (ev && !exp_rel) begin
            mq[tq].push_back(8'(eh));
            inuse[eh] = 1'b1;
        end
        @(negedge clk);
        enq_valid = 1'b0;
        deq_req   = 1'b0;
    endtask

    initial begin
        #2ms;
        fails++;
        $display("FAIL watchdog: actual %0d expected %0d", 0, 1);
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        int h;
        void'($urandom(32'd7781));
        repeat (5) @(negedge clk);
        rst_n = 1'b1;
        buf_used = 10'd0;

        // R1: every port empty after reset
        for (int p = 0; p < 10; p++) step(0, 0, 0, 0, 1, p, "R1");

        // R2: small port, prio 1 -> class 0, prio 5 -> class 1; FIFO in class 0
        step(1, 3, 1, 20, 0, 0, "R2");
        step(1, 3, 1, 21, 0, 0, "R2");
        step(1, 3, 5, 22, 0, 0, "R2");
        step(0, 0, 0, 0, 1, 3, "R4");   // class 1 first
        step(0, 0, 0, 0, 1, 3, "R2");   // then 20
        step(0, 0, 0, 0, 1, 3, "R2");   // then 21
        step(0, 0, 0, 0, 1, 3, "R9");   // empty

        // R3: big port, prio 2 -> class 1, prio 6 -> class 3, prio 4 -> class 2
        step(1, 8, 2, 30, 0, 0, "R3");
        step(1, 8, 6, 31, 0, 0, "R3");
        step(1, 9, 4, 32, 0, 0, "R3");
        step(0, 0, 0, 0, 1, 8, "R3");
        step(0, 0, 0, 0, 1, 8, "R3");
        step(0, 0, 0, 0, 1, 9, "R3");

        // R10: append and dequeue on a one-entry queue in the same cycle
        step(1, 0, 0, 40, 0, 0, "R10");
        step(1, 0, 0, 41, 1, 0, "R10");
        step(1, 0, 0, 42, 1, 0, "R10");
        step(0, 0, 0, 0, 1, 0, "R10");
        step(0, 0, 0, 0, 1, 0, "R10");

        // R7: out-of-range port is dropped and cannot be dequeued
        step(1, 12, 3, 50, 1, 11, "R7");

        // R5: usage exactly at threshold drops, one below admits
        buf_used = buf_limit;
        step(1, 2, 0, 60, 0, 0, "R5");
        buf_used = buf_limit - 10'd1;
        step(1, 2, 0, 61, 0, 0, "R5");
        buf_used = 10'd0;
        step(0, 0, 0, 0, 1, 2, "R5");

        // R6: queue filled exactly to its limit, then one more is dropped
        q_limit = 9'd2;
        step(1, 5, 7, 70, 0, 0, "R6");
        step(1, 5, 7, 71, 0, 0, "R6");
        step(1, 5, 7, 72, 0, 0, "R6");
        step(0, 0, 0, 0, 1, 5, "R6");
        step(0, 0, 0, 0, 1, 5, "R6");

        // Random traffic
        for (int i = 0; i < 4000; i++) begin
            if (i % 250 == 0) q_limit = 9'($urandom_range(1, 7));
            buf_used = 10'($urandom_range(160, 210));
            do h = int'($urandom_range(0, 255)); while (inuse[h]);
            step($urandom_range(0, 9) < 6, int'($urandom_range(0, 11)),
                 int'($urandom_range(0, 7)), h,
                 $urandom_range(0, 9) < 5, int'($urandom_range(0, 10)), "");
        end

        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end
endmodule